// File: doc/BRIEF.md
# DMA Window Validation Unit

This unit screens every inbound device DMA request before it reaches memory. A request carries a 16-bit requester ID (bus, device and function), a 64-bit DMA address and a write flag. The requester ID is matched against a small associative table that yields an isolation context number. The context and one high address bit then pick one of two window descriptors. Each descriptor holds an enable, a mode and a half-open bound `[base, limit)`. The mode is either translate, where the IOMMU walk is done elsewhere, or bypass, where the address is used as-is.

The request ends in one of three outcomes. A bypass hit is passed through with its physical address. A translate hit becomes a translation request that carries the context and the offset into the window. Anything else is a range error, and no address is forwarded. The first error in a context stores the faulting address and freezes that context. A frozen context rejects every later request until software thaws it through the configuration port. The same port loads the requester map and the descriptors.

Top module: `dma_win_check`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` is 0, every map entry and every descriptor is disabled, and no context reads back as frozen.
- R2: The requester ID is compared with every enabled map entry, and the lowest-numbered matching entry supplies the context. If no entry matches, the result is an error with `rsp_ctx` = 0 and `rsp_addr` = the request address, and no context is frozen.
- R3: Address bit 59 picks the descriptor of the context. When the bit is clear, descriptor 0 (`cfg_slot[0]`=0) is used. When the bit is set, descriptor 1 is used.
- R4: The effective address is the DMA address with bit 59 forced to 0. A hit needs `base <= effective < limit`. Any other effective address gives an error (`rsp_kind` 2) with `rsp_addr` = the original address.
- R5: A request that selects a disabled descriptor gives an error.
- R6: A hit on a bypass descriptor gives `rsp_kind` 0 with `rsp_addr` = the effective address.
- R7: A hit on a translate descriptor gives `rsp_kind` 1 with `rsp_addr` = effective − base and `rsp_ctx` = the context.
- R8: An error in a mapped context that is not frozen stores the full DMA address in that context's record and freezes the context. Both can be read through `flt_ctx`/`flt_addr`/`flt_frozen`.
- R9: A request in a frozen context gives an error and leaves the stored address unchanged. `cfg_op` 2 thaws `cfg_ctx`. If a thaw and a new error for the same context fall in the same cycle, the context ends up frozen.
- R10: `req_ready` = !`rsp_valid` || `rsp_ready`. The result of an accepted request appears in the next cycle and stays stable while stalled. `rsp_write` echoes the request's write flag, and results come out in request order.
- R11: A configuration write (`cfg_op` 0 map, 1 descriptor) takes effect for requests accepted in later cycles. A request accepted in the same cycle as the write sees the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_rid | input | 16 | Requester ID |
| req_addr | input | 64 | DMA address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumed |
| rsp_kind | output | 2 | 0 pass-through, 1 translate, 2 error |
| rsp_addr | output | 64 | Physical address, window offset, or faulting address |
| rsp_ctx | output | CTX_W | Context of the request (0 when unmapped) |
| rsp_write | output | 1 | Echoed write flag |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_op | input | 2 | 0 map entry, 1 descriptor, 2 thaw, 3 no-op |
| cfg_ctx | input | CTX_W | Target context |
| cfg_slot | input | clog2(MAP_N) | Map entry index; bit 0 is the descriptor number |
| cfg_rid | input | 16 | Requester ID for a map entry |
| cfg_enable | input | 1 | Enable for the map entry or descriptor |
| cfg_bypass | input | 1 | Descriptor mode: 1 bypass, 0 translate |
| cfg_base | input | 64 | Window base (inclusive) |
| cfg_limit | input | 64 | Window limit (exclusive) |
| flt_ctx | input | CTX_W | Context whose fault record is read |
| flt_addr | output | 64 | Stored faulting address |
| flt_frozen | output | 1 | Freeze state of `flt_ctx` |

## Verification
The bench builds the unit with CTX_W=2 and MAP_N=4, which gives four contexts, eight descriptors and four map slots. That is small enough to sweep every descriptor in both select-bit states at base−1, base, base+1, limit−1 and limit, and to read back and thaw every context's fault record after each error. With four slots the bench can load a duplicate requester ID, check the priority between entries, and re-route a requester by disabling an entry. The bench also covers the same-cycle cases: a thaw against a new error, and a configuration write against a request.

// File: rtl/dwc_pkg.sv
`timescale 1ns/1ps
package dwc_pkg;
  typedef enum logic [1:0] {RES_PASS = 2'd0, RES_XLATE = 2'd1, RES_ERR = 2'd2} res_e;
  typedef enum logic [1:0] {OP_MAP = 2'd0, OP_DESC = 2'd1, OP_THAW = 2'd2, OP_NONE = 2'd3} op_e;

  typedef struct packed {
    logic        en;
    logic        bypass;
    logic [63:0] base;
    logic [63:0] limit;
  } desc_t;

  // effective address: the descriptor-select bit is not part of the address
  function automatic logic [63:0] strip_sel(input logic [63:0] a, input int unsigned pos);
    logic [63:0] r;
    r = a;
    r[pos] = 1'b0;
    return r;
  endfunction

  // half-open window [base, limit)
  function automatic logic in_window(input logic [63:0] eff, input logic [63:0] base,
                                     input logic [63:0] limit);
    return (eff >= base) && (eff < limit);
  endfunction
endpackage

// File: rtl/dwc_rid_map.sv
`timescale 1ns/1ps
module dwc_rid_map #(
  parameter int MAP_N = 8,
  parameter int CTX_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(MAP_N)-1:0] wr_slot,
  input  logic [15:0]              wr_rid,
  input  logic [CTX_W-1:0]         wr_ctx,
  input  logic                     wr_valid,
  input  logic [15:0]              lk_rid,
  output logic                     lk_hit,
  output logic [CTX_W-1:0]         lk_ctx
);
  logic [MAP_N-1:0] ent_vld;
  logic [MAP_N-1:0] ent_match;
  logic [15:0]      ent_rid [MAP_N];
  logic [CTX_W-1:0] ent_ctx [MAP_N];

  for (genvar g = 0; g < MAP_N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_vld[g] <= 1'b0;
        ent_rid[g] <= '0;
        ent_ctx[g] <= '0;
      end else if (wr_en && (wr_slot == g)) begin
        ent_vld[g] <= wr_valid;
        ent_rid[g] <= wr_rid;
        ent_ctx[g] <= wr_ctx;
      end
    end
    assign ent_match[g] = ent_vld[g] && (ent_rid[g] == lk_rid);
  end

  // lowest index wins: scan downward so the last overwrite is entry 0
  always_comb begin
    lk_hit = 1'b0;
    lk_ctx = '0;
    for (int i = MAP_N - 1; i >= 0; i--) begin
      if (ent_match[i]) begin
        lk_hit = 1'b1;
        lk_ctx = ent_ctx[i];
      end
    end
  end

  AST_HIT_HAS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ($countones(ent_match) >= 1)); // R2
endmodule

// File: rtl/dwc_desc_table.sv
`timescale 1ns/1ps
module dwc_desc_table
  import dwc_pkg::*;
#(
  parameter int CTX_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CTX_W:0] wr_idx,
  input  desc_t          wr_desc,
  input  logic [CTX_W:0] rd_idx,
  output desc_t          rd_desc
);
  localparam int ND = 2 << CTX_W;

  desc_t tbl [ND];

  for (genvar g = 0; g < ND; g++) begin : g_desc
    always_ff @(posedge clk) begin
      if (!rst_n) tbl[g] <= '0;
      else if (wr_en && (wr_idx == g)) tbl[g] <= wr_desc;
    end
  end

  assign rd_desc = tbl[rd_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (rd_idx == wr_idx) |=> (rd_idx != $past(wr_idx)) || (rd_desc == $past(wr_desc))); // R11
endmodule

// File: rtl/dwc_fault_log.sv
`timescale 1ns/1ps
module dwc_fault_log #(
  parameter int CTX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   log_en,
  input  logic [CTX_W-1:0]       log_ctx,
  input  logic [63:0]            log_addr,
  input  logic                   thaw_en,
  input  logic [CTX_W-1:0]       thaw_ctx,
  output logic [(1<<CTX_W)-1:0]  frozen_vec,
  input  logic [CTX_W-1:0]       rd_ctx,
  output logic [63:0]            rd_addr
);
  localparam int NCTX = 1 << CTX_W;

  logic [63:0] rec_addr [NCTX];

  for (genvar g = 0; g < NCTX; g++) begin : g_rec
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        frozen_vec[g] <= 1'b0;
        rec_addr[g]   <= '0;
      end else if (log_en && (log_ctx == g)) begin
        frozen_vec[g] <= 1'b1;            // a new fault outranks a thaw
        rec_addr[g]   <= log_addr;
      end else if (thaw_en && (thaw_ctx == g)) begin
        frozen_vec[g] <= 1'b0;
      end
    end
  end

  assign rd_addr = rec_addr[rd_ctx];

  AST_LOG_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    log_en |=> frozen_vec[$past(log_ctx)]); // R8
  AST_THAW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    thaw_en && !(log_en && (log_ctx == thaw_ctx)) |=> !frozen_vec[$past(thaw_ctx)]); // R9
endmodule

// File: rtl/dma_win_check.sv
`timescale 1ns/1ps
module dma_win_check
  import dwc_pkg::*;
#(
  parameter int CTX_W   = 3,
  parameter int MAP_N   = 8,
  parameter int SEL_BIT = 59
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [15:0]              req_rid,
  input  logic [63:0]              req_addr,
  input  logic                     req_write,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [1:0]               rsp_kind,
  output logic [63:0]              rsp_addr,
  output logic [CTX_W-1:0]         rsp_ctx,
  output logic                     rsp_write,
  input  logic                     cfg_valid,
  input  logic [1:0]               cfg_op,
  input  logic [CTX_W-1:0]         cfg_ctx,
  input  logic [$clog2(MAP_N)-1:0] cfg_slot,
  input  logic [15:0]              cfg_rid,
  input  logic                     cfg_enable,
  input  logic                     cfg_bypass,
  input  logic [63:0]              cfg_base,
  input  logic [63:0]              cfg_limit,
  input  logic [CTX_W-1:0]         flt_ctx,
  output logic [63:0]              flt_addr,
  output logic                     flt_frozen
);
  localparam int NCTX = 1 << CTX_W;

  logic             accept;
  logic             map_hit;
  logic [CTX_W-1:0] map_ctx;
  logic             sel_bit;
  logic [63:0]      eff_addr;
  desc_t            cur_desc;
  desc_t            new_desc;
  logic [NCTX-1:0]  frz_vec;
  logic             ctx_frozen;
  logic             win_ok;
  res_e             nxt_kind;
  logic [63:0]      nxt_addr;
  logic             log_en;
  logic             map_we;
  logic             desc_we;
  logic             thaw_we;

  assign map_we  = cfg_valid && (cfg_op == OP_MAP);
  assign desc_we = cfg_valid && (cfg_op == OP_DESC);
  assign thaw_we = cfg_valid && (cfg_op == OP_THAW);

  assign new_desc.en     = cfg_enable;
  assign new_desc.bypass = cfg_bypass;
  assign new_desc.base   = cfg_base;
  assign new_desc.limit  = cfg_limit;

  dwc_rid_map #(.MAP_N(MAP_N), .CTX_W(CTX_W)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_en(map_we), .wr_slot(cfg_slot), .wr_rid(cfg_rid),
    .wr_ctx(cfg_ctx), .wr_valid(cfg_enable), .lk_rid(req_rid), .lk_hit(map_hit),
    .lk_ctx(map_ctx));

  assign sel_bit  = req_addr[SEL_BIT];
  assign eff_addr = strip_sel(req_addr, SEL_BIT);

  dwc_desc_table #(.CTX_W(CTX_W)) u_desc (
    .clk(clk), .rst_n(rst_n), .wr_en(desc_we), .wr_idx({cfg_ctx, cfg_slot[0]}),
    .wr_desc(new_desc), .rd_idx({map_ctx, sel_bit}), .rd_desc(cur_desc));

  dwc_fault_log #(.CTX_W(CTX_W)) u_flt (
    .clk(clk), .rst_n(rst_n), .log_en(log_en), .log_ctx(map_ctx), .log_addr(req_addr),
    .thaw_en(thaw_we), .thaw_ctx(cfg_ctx), .frozen_vec(frz_vec), .rd_ctx(flt_ctx),
    .rd_addr(flt_addr));

  assign ctx_frozen = frz_vec[map_ctx];
  assign flt_frozen = frz_vec[flt_ctx];
  assign win_ok     = in_window(eff_addr, cur_desc.base, cur_desc.limit);

  always_comb begin
    nxt_kind = RES_ERR;
    nxt_addr = req_addr;
    if (map_hit && !ctx_frozen && cur_desc.en && win_ok) begin
      if (cur_desc.bypass) begin
        nxt_kind = RES_PASS;
        nxt_addr = eff_addr;
      end else begin
        nxt_kind = RES_XLATE;
        nxt_addr = eff_addr - cur_desc.base;
      end
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign log_en    = accept && map_hit && !ctx_frozen && (nxt_kind == RES_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= RES_PASS;
      rsp_addr  <= '0;
      rsp_ctx   <= '0;
      rsp_write <= 1'b0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_kind  <= nxt_kind;
        rsp_addr  <= nxt_addr;
        rsp_ctx   <= map_hit ? map_ctx : '0;
        rsp_write <= req_write;
      end
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_addr)
                                && $stable(rsp_ctx) && $stable(rsp_write)); // R10
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_kind != 2'd3)); // R10
  AST_BYPASS_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_kind == RES_PASS) |-> !rsp_addr[SEL_BIT]); // R6
  AST_FROZEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && map_hit && ctx_frozen |=> rsp_valid && (rsp_kind == RES_ERR)); // R9
  AST_DISABLED_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    accept && map_hit && !cur_desc.en |=> rsp_valid && (rsp_kind == RES_ERR)); // R5
  AST_MISS_CTX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !map_hit |=> (rsp_ctx == '0) && (rsp_kind == RES_ERR)); // R2
endmodule

// File: tb/sim_dma_win_check.sv
`timescale 1ns/1ps
module sim_dma_win_check;
  localparam int CW = 2;
  localparam int MN = 4;
  localparam logic [63:0] SELM = 64'h1 << 59;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [15:0] req_rid = 0;
  logic [63:0] req_addr = 0;
  logic req_ready, rsp_valid, rsp_write, flt_frozen;
  logic [1:0] rsp_kind;
  logic [63:0] rsp_addr, flt_addr;
  logic [CW-1:0] rsp_ctx;
  logic cfg_valid = 0, cfg_enable = 0, cfg_bypass = 0;
  logic [1:0] cfg_op = 3;
  logic [CW-1:0] cfg_ctx = 0, flt_ctx = 0;
  logic [1:0] cfg_slot = 0;
  logic [15:0] cfg_rid = 0;
  logic [63:0] cfg_base = 0, cfg_limit = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench-side model state
  bit          m_vld [MN];
  logic [15:0] m_rid [MN];
  int          m_ctx [MN];
  bit          d_en [8];
  bit          d_byp [8];
  logic [63:0] d_base [8];
  logic [63:0] d_lim [8];
  bit          m_frz [4];
  logic [63:0] m_faddr [4];

  dma_win_check #(.CTX_W(CW), .MAP_N(MN), .SEL_BIT(59)) u0 (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int op, input int ctx, input int slot, input logic [15:0] rid,
                     input bit en, input bit byp, input logic [63:0] b, input logic [63:0] l);
    @(negedge clk);
    cfg_valid = 1; cfg_op = op[1:0]; cfg_ctx = ctx[CW-1:0]; cfg_slot = slot[1:0];
    cfg_rid = rid; cfg_enable = en; cfg_bypass = byp; cfg_base = b; cfg_limit = l;
    @(negedge clk);
    cfg_valid = 0; cfg_op = 3;
    if (op == 0) begin m_vld[slot] = en; m_rid[slot] = rid; m_ctx[slot] = ctx; end
    if (op == 1) begin
      d_en[ctx*2+slot%2] = en; d_byp[ctx*2+slot%2] = byp;
      d_base[ctx*2+slot%2] = b; d_lim[ctx*2+slot%2] = l;
    end
    if (op == 2) m_frz[ctx] = 0;
  endtask

  // expected outcome from the requirement text (kinds: 0 pass, 1 translate, 2 error)
  task automatic predict(input logic [15:0] rid, input logic [63:0] a,
                         output int ek, output logic [63:0] ea, output int ec, output bit hit);
    logic [63:0] eff;
    int di;
    hit = 0; ec = 0;
    for (int s = 0; s < MN; s++)
      if (!hit && m_vld[s] && m_rid[s] == rid) begin hit = 1; ec = m_ctx[s]; end
    eff = a & ~SELM;
    di = ec * 2 + int'(a[59]);
    ek = 2; ea = a;
    if (hit && !m_frz[ec] && d_en[di] && eff >= d_base[di] && eff < d_lim[di]) begin
      if (d_byp[di]) begin ek = 0; ea = eff; end
      else begin ek = 1; ea = eff - d_base[di]; end
    end
  endtask

  task automatic send(input logic [15:0] rid, input logic [63:0] a, input bit wr, input string tag);
    int ek, ec; logic [63:0] ea; bit hit;
    predict(rid, a, ek, ea, ec, hit);
    @(negedge clk);
    req_valid = 1; req_rid = rid; req_addr = a; req_write = wr;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid && rsp_kind == ek[1:0] && rsp_write == wr, {tag, " kind"}, 64'(rsp_kind), 64'(ek));
    chk(rsp_addr == ea && rsp_ctx == ec[CW-1:0], {tag, " addr"}, rsp_addr, ea);
    if (ek == 2 && hit && !m_frz[ec]) begin m_frz[ec] = 1; m_faddr[ec] = a; end
  endtask

  task automatic probe(input int c, input string tag);
    flt_ctx = c[CW-1:0];
    #0.5;
    chk(flt_frozen == m_frz[c], {tag, " frozen"}, 64'(flt_frozen), 64'(m_frz[c]));
    if (m_frz[c]) chk(flt_addr == m_faddr[c], {tag, " record"}, flt_addr, m_faddr[c]);
  endtask

  logic [15:0] ridof [4] = '{16'h0008, 16'h0110, 16'h0220, 16'h0330};

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin d_en[i] = 0; d_byp[i] = 0; d_base[i] = 0; d_lim[i] = 0; end
    for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_frz[i] = 0; m_faddr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(req_ready == 1 && rsp_valid == 0, "R1 handshake", 64'({req_ready, rsp_valid}), 64'h2);
    for (int c = 0; c < 4; c++) probe(c, "R1");
    // R2: unmapped requester
    send(16'h0008, 64'h100, 0, "R2 empty map");
    for (int s = 0; s < 4; s++) cfg(0, s, s, ridof[s], 1, 0, 0, 0);
    // R5: descriptors still disabled
    send(16'h0110, 64'h1800, 1, "R5 disabled");
    probe(1, "R8 disabled fault");
    cfg(2, 1, 0, 0, 0, 0, 0, 0);
    probe(1, "R9 thaw");
    cfg(1, 0, 0, 0, 1, 0, 64'h0, 64'h8000_0000);
    cfg(1, 0, 1, 0, 1, 1, 64'h0, SELM);
    cfg(1, 1, 0, 0, 1, 1, 64'h1000, 64'h2000);
    cfg(1, 1, 1, 0, 1, 0, 64'h10_0000_0000, 64'h20_0000_0000);
    cfg(1, 2, 1, 0, 1, 0, 64'h4000, 64'h5000);
    cfg(1, 3, 0, 0, 1, 0, 64'h100, 64'h100);
    cfg(1, 3, 1, 0, 1, 1, 64'h2_0000_0000, 64'h3_0000_0000);
    // R3 R4 R6 R7 R8: boundary sweep of every descriptor in both select states
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 2; s++) begin
        logic [63:0] b, l, pts[6];
        b = d_en[c*2+s] ? d_base[c*2+s] : 64'h0;
        l = d_en[c*2+s] ? d_lim[c*2+s] : 64'h1000;
        pts = '{(b == 0) ? b + 2 : b - 1, b, b + 1, l - 1, l, l | (64'h1 << 62)};
        for (int p = 0; p < 6; p++) begin
          send(ridof[c], pts[p] | (s ? SELM : 64'h0), p[0], "R4 sweep");
          probe(c, "R8 sweep");
          if (m_frz[c]) cfg(2, c, 0, 0, 0, 0, 0, 0);
        end
      end
    // R4: high address without the select bit fails the 2 GiB window
    send(16'h0008, 64'h0000_2039_74C0_0000, 0, "R4 wide addr");
    probe(0, "R8 wide addr");
    // R9: frozen context rejects a good request and keeps the first record
    send(16'h0008, 64'h1000, 0, "R9 frozen reject");
    probe(0, "R9 record kept");
    cfg(2, 0, 0, 0, 0, 0, 0, 0);
    send(16'h0008, 64'h1000, 0, "R9 after thaw");
    // R9: thaw and a new fault in the same cycle leave the context frozen
    @(negedge clk);
    cfg_valid = 1; cfg_op = 2; cfg_ctx = 2;
    req_valid = 1; req_rid = 16'h0220; req_addr = 64'h40; req_write = 0;
    @(negedge clk);
    cfg_valid = 0; cfg_op = 3; req_valid = 0;
    chk(rsp_valid && rsp_kind == 2, "R9 same-cycle kind", 64'(rsp_kind), 64'h2);
    m_frz[2] = 1; m_faddr[2] = 64'h40;
    probe(2, "R9 set wins");
    cfg(2, 2, 0, 0, 0, 0, 0, 0);
    // R11: write in the same cycle as a request uses the old descriptor
    @(negedge clk);
    cfg_valid = 1; cfg_op = 1; cfg_ctx = 1; cfg_slot = 0; cfg_enable = 0;
    req_valid = 1; req_rid = 16'h0110; req_addr = 64'h1800; req_write = 1;
    @(negedge clk);
    cfg_valid = 0; cfg_op = 3; req_valid = 0;
    chk(rsp_valid && rsp_kind == 0 && rsp_addr == 64'h1800, "R11 old config", rsp_addr, 64'h1800);
    d_en[2] = 0;
    send(16'h0110, 64'h1800, 1, "R11 new config");
    cfg(2, 1, 0, 0, 0, 0, 0, 0);
    // R2: duplicate requester ID, lowest slot wins, then re-route
    cfg(0, 3, 3, 16'h0008, 1, 0, 0, 0);
    send(16'h0008, SELM | 64'h2_0000_0010, 0, "R2 priority");
    cfg(0, 0, 0, 16'h0008, 0, 0, 0, 0);
    send(16'h0008, SELM | 64'h2_0000_0010, 1, "R2 reroute");
    chk(rsp_ctx == 3, "R2 reroute ctx", 64'(rsp_ctx), 64'h3);
    cfg(0, 0, 0, 16'h0008, 1, 0, 0, 0);
    // R10: stall holds the result, next request waits, order kept
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_rid = 16'h0008; req_addr = SELM | 64'h1234; req_write = 1;
    @(negedge clk);
    req_addr = 64'h5000; req_write = 0;
    repeat (2) @(negedge clk);
    chk(rsp_valid && rsp_addr == 64'h1234 && rsp_write == 1 && rsp_kind == 0, "R10 held", rsp_addr, 64'h1234);
    chk(req_ready == 0, "R10 backpressure", 64'(req_ready), 64'h0);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid && rsp_addr == 64'h5000 && rsp_kind == 1 && rsp_write == 0, "R10 next in order", rsp_addr, 64'h5000);
    @(negedge clk);
    chk(rsp_valid == 0, "R10 drained", 64'(rsp_valid), 64'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule